// File: doc/BRIEF.md
# Pixel-Row Readout Timing Sequencer

This block drives the control lines for reading one pixel row in a column-parallel image sensor. The sensor takes repeated samples of both the reset level and the signal level, and subtracts them digitally in the column counters. A single-cycle start request in idle begins a row. The sequencer then runs through these phases in order:

1. Pixel reset.
2. Two offset-storing pulses, first the column amplifier and then the comparator.
3. A programmable number M of ramp up/down cycles that digitise the reset level.
4. A charge-transfer window. The counters' one's-complement invert pulse falls inside this window.
5. M more ramp cycles, set up the same way, that digitise the signal level.

A one-cycle done pulse ends the row. Row select and the sample-hold switch stay closed for the whole conversion.

All phase lengths and M are captured when the row starts. Changing them during a row therefore has no effect on that row. The ramp's analog shape, frame-level row addressing and column data readout belong to other blocks.

Top module: `row_seq_top`

## Requirements
- R1: While reset is held, and in idle after it, every output is low.
- R2: A start seen in idle makes row select and pixel reset rise together on the following cycle. Pixel reset stays high for `rst_len_i` cycles, and a value of 0 counts as 1.
- R3: Right after pixel reset, amplifier reset is high for `az_len_i` cycles. Comparator auto-zero follows directly for another `az_len_i` cycles. A value of 0 counts as 1.
- R4: Reset-level sampling runs M ramp cycles back to back. In each cycle the ramp is first high for `up_len_i` cycles with direction 1 and the counter window open. It then runs `dn_len_i` cycles with direction 0 and the window closed. A value of 0 counts as 1.
- R5: The effective M is `m_cfg_i`, with two exceptions: 0 becomes 1 (plain CDS) and any value above 8 becomes 8.
- R6: The transfer gate opens on the cycle after the last reset ramp-down. It stays open for max(X, I+2) cycles, where X and I are the transfer and invert lengths after the 0-to-1 rule.
- R7: The invert pulse is high for I cycles, starting on the second transfer cycle. It therefore begins after the last reset counter window has closed and ends before the first signal counter window opens.
- R8: Signal-level sampling follows the transfer at once and repeats the R4 pattern M times.
- R9: Row select and the sample-hold switch are high from the first pixel-reset cycle through the last signal ramp-down cycle, and low otherwise.
- R10: Done is high for exactly one cycle, the one after the last signal ramp-down. All other outputs are low on that cycle, and the block is idle afterwards.
- R11: A start that arrives during a row is ignored. Changes to M or to a length during a row do not alter that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Row start request |
| m_cfg_i | input | 4 | Sample count M |
| rst_len_i | input | 8 | Pixel reset width |
| az_len_i | input | 8 | Width of each auto-zero pulse |
| up_len_i | input | 8 | Ramp up length |
| dn_len_i | input | 8 | Ramp down length |
| xfer_len_i | input | 8 | Transfer gate width |
| inv_len_i | input | 8 | Invert pulse width |
| row_sel_o | output | 1 | Row select |
| pix_rst_o | output | 1 | Pixel reset |
| amp_rst_o | output | 1 | Column amplifier reset |
| cmp_az_o | output | 1 | Comparator auto-zero |
| tx_o | output | 1 | Transfer gate |
| sh_o | output | 1 | Sample-hold switch |
| ramp_run_o | output | 1 | Ramp running |
| ramp_up_o | output | 1 | Ramp direction, 1 = up |
| cnt_en_o | output | 1 | Counter window |
| inv_o | output | 1 | Counter bit-invert pulse |
| done_o | output | 1 | Row finished |

## Verification
Every output comes from registered phase state, so each result appears exactly one clock edge after the edge that caused it. The first row cycle is therefore the cycle right after the start is captured. With R, A, U, D, X' and M the effective values, done is due on cycle R+2A+2M(U+D)+X'+1 counted from that edge. The bench samples once per cycle on the falling edge and numbers cycles from the capturing edge. It then compares the cycle on which each control first rises, how many cycles it stays high and how many windows open before the invert pulse. All of these expected values come from closed-form sums computed from the requirements.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_PRST, PH_AMPZ, PH_CMPZ, PH_RUP, PH_RDN,
    PH_XFER, PH_SUP, PH_SDN, PH_DONE
  } phase_e;
endpackage

// File: rtl/row_seq_cfg.sv
module row_seq_cfg #(
  parameter int CNT_W = 8,
  parameter int M_W   = 4,
  parameter int M_MAX = 8,
  localparam int LW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [M_W-1:0]   m_cfg_i,
  input  logic [CNT_W-1:0] rst_len_i,
  input  logic [CNT_W-1:0] az_len_i,
  input  logic [CNT_W-1:0] up_len_i,
  input  logic [CNT_W-1:0] dn_len_i,
  input  logic [CNT_W-1:0] xfer_len_i,
  input  logic [CNT_W-1:0] inv_len_i,
  output logic [M_W-1:0]   m_q,
  output logic [LW-1:0]    rst_q,
  output logic [LW-1:0]    az_q,
  output logic [LW-1:0]    up_q,
  output logic [LW-1:0]    dn_q,
  output logic [LW-1:0]    xfer_q,
  output logic [LW-1:0]    inv_q
);
  // zero length counts as one cycle
  function automatic logic [LW-1:0] len_fix(input logic [CNT_W-1:0] v);
    return (v == '0) ? LW'(1) : LW'(v);
  endfunction

  function automatic logic [M_W-1:0] m_fix(input logic [M_W-1:0] v);
    if (v == '0) return M_W'(1);
    if (int'(v) > M_MAX) return M_W'(M_MAX);
    return v;
  endfunction

  // transfer window must hold one lead cycle, the pulse, and one trail cycle
  function automatic logic [LW-1:0] xfer_fix(input logic [LW-1:0] x, input logic [LW-1:0] i);
    return (x < i + LW'(2)) ? i + LW'(2) : x;
  endfunction

  logic [LW-1:0] inv_fix;
  assign inv_fix = len_fix(inv_len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= M_W'(1); rst_q <= LW'(1); az_q <= LW'(1); up_q <= LW'(1);
      dn_q <= LW'(1); xfer_q <= LW'(3); inv_q <= LW'(1);
    end else if (take_i) begin
      m_q    <= m_fix(m_cfg_i);
      rst_q  <= len_fix(rst_len_i);
      az_q   <= len_fix(az_len_i);
      up_q   <= len_fix(up_len_i);
      dn_q   <= len_fix(dn_len_i);
      xfer_q <= xfer_fix(len_fix(xfer_len_i), inv_fix);
      inv_q  <= inv_fix;
    end
  end
endmodule

// File: rtl/row_seq_ctrl.sv
module row_seq_ctrl
  import row_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int M_W   = 4,
  parameter int M_MAX = 8,
  localparam int LW   = CNT_W + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [M_W-1:0] m_q,
  input  logic [LW-1:0]  rst_q,
  input  logic [LW-1:0]  az_q,
  input  logic [LW-1:0]  up_q,
  input  logic [LW-1:0]  dn_q,
  input  logic [LW-1:0]  xfer_q,
  input  logic [LW-1:0]  inv_q,
  output logic           take_o,
  output phase_e         phase_o,
  output logic           inv_win_o
);
  phase_e        ph_q;
  logic [LW-1:0] cnt_q;
  logic [M_W-1:0] rep_q;
  logic [LW-1:0] len_cur;
  logic          phase_end;
  logic          last_rep;

  assign take_o = (ph_q == PH_IDLE) && start_i;

  always_comb begin
    unique case (ph_q)
      PH_PRST:        len_cur = rst_q;
      PH_AMPZ, PH_CMPZ: len_cur = az_q;
      PH_RUP, PH_SUP: len_cur = up_q;
      PH_RDN, PH_SDN: len_cur = dn_q;
      PH_XFER:        len_cur = xfer_q;
      default:        len_cur = LW'(1);
    endcase
  end

  assign phase_end = (cnt_q == len_cur - LW'(1));
  assign last_rep  = (rep_q == m_q - M_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; cnt_q <= '0; rep_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      cnt_q <= '0; rep_q <= '0;
      if (start_i) ph_q <= PH_PRST;
    end else if (!phase_end) begin
      cnt_q <= cnt_q + LW'(1);
    end else begin
      cnt_q <= '0;
      unique case (ph_q)
        PH_PRST: ph_q <= PH_AMPZ;
        PH_AMPZ: ph_q <= PH_CMPZ;
        PH_CMPZ: ph_q <= PH_RUP;
        PH_RUP:  ph_q <= PH_RDN;
        PH_SUP:  ph_q <= PH_SDN;
        PH_XFER: ph_q <= PH_SUP;
        PH_RDN, PH_SDN: begin
          if (last_rep) begin
            rep_q <= '0;
            ph_q  <= (ph_q == PH_RDN) ? PH_XFER : PH_DONE;
          end else begin
            rep_q <= rep_q + M_W'(1);
            ph_q  <= (ph_q == PH_RDN) ? PH_RUP : PH_SUP;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o   = ph_q;
  assign inv_win_o = (ph_q == PH_XFER) && (cnt_q != '0) && (cnt_q <= inv_q);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q < m_q); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_cur); // R4
  AST_M_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_q != '0) && (int'(m_q) <= M_MAX)); // R5
endmodule

// File: rtl/row_seq_dec.sv
module row_seq_dec
  import row_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_i,
  input  logic   inv_win_i,
  output logic   row_sel_o,
  output logic   pix_rst_o,
  output logic   amp_rst_o,
  output logic   cmp_az_o,
  output logic   tx_o,
  output logic   sh_o,
  output logic   ramp_run_o,
  output logic   ramp_up_o,
  output logic   cnt_en_o,
  output logic   inv_o,
  output logic   done_o
);
  logic in_row;
  assign in_row     = (phase_i != PH_IDLE) && (phase_i != PH_DONE);
  assign row_sel_o  = in_row;
  assign sh_o       = in_row;
  assign pix_rst_o  = (phase_i == PH_PRST);
  assign amp_rst_o  = (phase_i == PH_AMPZ);
  assign cmp_az_o   = (phase_i == PH_CMPZ);
  assign tx_o       = (phase_i == PH_XFER);
  assign ramp_up_o  = (phase_i == PH_RUP) || (phase_i == PH_SUP);
  assign ramp_run_o = ramp_up_o || (phase_i == PH_RDN) || (phase_i == PH_SDN);
  assign cnt_en_o   = ramp_up_o;
  assign inv_o      = inv_win_i;
  assign done_o     = (phase_i == PH_DONE);

  AST_INV_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    inv_o |-> tx_o && !cnt_en_o); // R7
  AST_INV_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_o) |-> $past(tx_o)); // R7
  AST_AMP_THEN_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_az_o) |-> $past(amp_rst_o)); // R3
  AST_PIX_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rst_o |-> row_sel_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !row_sel_o); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !row_sel_o && !ramp_run_o && !tx_o); // R10
endmodule

// File: rtl/row_seq_top.sv
module row_seq_top
  import row_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int M_W   = 4,
  parameter int M_MAX = 8,
  localparam int LW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [M_W-1:0]   m_cfg_i,
  input  logic [CNT_W-1:0] rst_len_i,
  input  logic [CNT_W-1:0] az_len_i,
  input  logic [CNT_W-1:0] up_len_i,
  input  logic [CNT_W-1:0] dn_len_i,
  input  logic [CNT_W-1:0] xfer_len_i,
  input  logic [CNT_W-1:0] inv_len_i,
  output logic             row_sel_o,
  output logic             pix_rst_o,
  output logic             amp_rst_o,
  output logic             cmp_az_o,
  output logic             tx_o,
  output logic             sh_o,
  output logic             ramp_run_o,
  output logic             ramp_up_o,
  output logic             cnt_en_o,
  output logic             inv_o,
  output logic             done_o
);
  logic           take;
  logic [M_W-1:0] m_q;
  logic [LW-1:0]  rst_q, az_q, up_q, dn_q, xfer_q, inv_q;
  phase_e         phase;
  logic           inv_win;

  row_seq_cfg #(.CNT_W(CNT_W), .M_W(M_W), .M_MAX(M_MAX)) cfg_i (
    .clk(clk), .rst_n(rst_n), .take_i(take), .m_cfg_i(m_cfg_i),
    .rst_len_i(rst_len_i), .az_len_i(az_len_i), .up_len_i(up_len_i),
    .dn_len_i(dn_len_i), .xfer_len_i(xfer_len_i), .inv_len_i(inv_len_i),
    .m_q(m_q), .rst_q(rst_q), .az_q(az_q), .up_q(up_q), .dn_q(dn_q),
    .xfer_q(xfer_q), .inv_q(inv_q)
  );

  row_seq_ctrl #(.CNT_W(CNT_W), .M_W(M_W), .M_MAX(M_MAX)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .m_q(m_q),
    .rst_q(rst_q), .az_q(az_q), .up_q(up_q), .dn_q(dn_q),
    .xfer_q(xfer_q), .inv_q(inv_q), .take_o(take),
    .phase_o(phase), .inv_win_o(inv_win)
  );

  row_seq_dec dec_i (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .inv_win_i(inv_win),
    .row_sel_o(row_sel_o), .pix_rst_o(pix_rst_o), .amp_rst_o(amp_rst_o),
    .cmp_az_o(cmp_az_o), .tx_o(tx_o), .sh_o(sh_o), .ramp_run_o(ramp_run_o),
    .ramp_up_o(ramp_up_o), .cnt_en_o(cnt_en_o), .inv_o(inv_o), .done_o(done_o)
  );

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel_o && start_i) |=> !$rose(pix_rst_o)); // R11
  AST_SH_TRACKS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    sh_o == row_sel_o); // R9
endmodule

// File: tb/row_seq_top_tb_top.sv
`timescale 1ns/1ps
module row_seq_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] m_cfg = '0;
  logic [7:0] rl = '0, al = '0, ul = '0, dl = '0, xl = '0, il = '0;
  logic row_sel, pix_rst, amp_rst, cmp_az, tx, sh, ramp_run, ramp_up, cnt_en, inv, done;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  row_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .m_cfg_i(m_cfg),
    .rst_len_i(rl), .az_len_i(al), .up_len_i(ul), .dn_len_i(dl),
    .xfer_len_i(xl), .inv_len_i(il),
    .row_sel_o(row_sel), .pix_rst_o(pix_rst), .amp_rst_o(amp_rst),
    .cmp_az_o(cmp_az), .tx_o(tx), .sh_o(sh), .ramp_run_o(ramp_run),
    .ramp_up_o(ramp_up), .cnt_en_o(cnt_en), .inv_o(inv), .done_o(done)
  );

  // fields: R A U D X I M, 8 bits each, R in the top byte
  localparam logic [55:0] VEC [6] = '{
    {8'd2, 8'd1, 8'd3, 8'd2, 8'd4, 8'd1, 8'd1},
    {8'd1, 8'd2, 8'd2, 8'd1, 8'd3, 8'd2, 8'd4},
    {8'd3, 8'd1, 8'd1, 8'd1, 8'd1, 8'd3, 8'd8},
    {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd2, 8'd1, 8'd2, 8'd3, 8'd5, 8'd2, 8'd15},
    {8'd1, 8'd3, 8'd1, 8'd2, 8'd9, 8'd4, 8'd2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int one(input int v); return (v == 0) ? 1 : v; endfunction

  task automatic run_row(input logic [55:0] v, input bit disturb);
    int R, A, U, D, X, I, M, T;
    int np = 0, na = 0, nc = 0, ntx = 0, ninv = 0, nce = 0, nrun = 0, nup = 0;
    int nrow = 0, nsh = 0, ndone = 0, rises = 0, rises_pre_inv = 0;
    int fa = 0, fc = 0, ftx = 0, finv = 0, linv = 0, fsig = 0, dcyc = 0, both1 = 0;
    bit prev_ce = 0;
    R = one(int'(v[55:48])); A = one(int'(v[47:40])); U = one(int'(v[39:32]));
    D = one(int'(v[31:24])); X = one(int'(v[23:16])); I = one(int'(v[15:8]));
    M = (v[7:0] == 0) ? 1 : ((v[7:0] > 8) ? 8 : int'(v[7:0]));
    if (X < I + 2) X = I + 2;
    T = R + 2*A + 2*M*(U + D) + X;
    @(negedge clk);
    rl = v[55:48]; al = v[47:40]; ul = v[39:32]; dl = v[31:24];
    xl = v[23:16]; il = v[15:8]; m_cfg = v[3:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n < 3000; n++) begin
      if (n == 1) both1 = int'(row_sel && pix_rst);
      np += int'(pix_rst); ntx += int'(tx); ninv += int'(inv); nce += int'(cnt_en);
      nrun += int'(ramp_run); nup += int'(ramp_up && ramp_run);
      nrow += int'(row_sel); nsh += int'(sh);
      if (amp_rst) begin na++; if (fa == 0) fa = n; end
      if (cmp_az) begin nc++; if (fc == 0) fc = n; end
      if (tx && ftx == 0) ftx = n;
      if (inv) begin if (finv == 0) begin finv = n; rises_pre_inv = rises; end linv = n; end
      if (cnt_en && !prev_ce) begin rises++; if (ftx != 0 && fsig == 0) fsig = n; end
      prev_ce = cnt_en;
      if (done) begin ndone++; dcyc = n; chk("R10 quiet at done", int'(row_sel|ramp_run|tx|inv), 0); break; end
      if (disturb && n == 4) begin start = 1'b1; m_cfg = 4'd3; ul = 8'd7; xl = 8'd20; end
      if (disturb && n == 5) start = 1'b0;
      @(negedge clk);
    end
    chk("R2 row_sel with pix_rst", both1, 1);
    chk("R2 pix_rst width", np, R);
    chk("R3 amp start", fa, R + 1);
    chk("R3 amp width", na, A);
    chk("R3 cmp start", fc, R + A + 1);
    chk("R3 cmp width", nc, A);
    chk("R4 R8 window count", rises, 2*M);
    chk("R4 R8 window cycles", nce, 2*M*U);
    chk("R4 R8 ramp up cycles", nup, 2*M*U);
    chk("R4 R8 ramp cycles", nrun, 2*M*(U + D));
    chk("R5 windows before invert", rises_pre_inv, M);
    chk("R6 tx start", ftx, R + 2*A + M*(U + D) + 1);
    chk("R6 tx width", ntx, X);
    chk("R7 invert start", finv, ftx + 1);
    chk("R7 invert width", ninv, I);
    chk("R7 invert ends before signal", int'(linv < fsig), 1);
    chk("R8 first signal window", fsig, ftx + X);
    chk("R9 row_sel cycles", nrow, T);
    chk("R9 sh cycles", nsh, T);
    chk("R10 done cycle", dcyc, T + 1);
    chk("R10 done count", ndone, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 R11 idle after done", int'(row_sel|done|ramp_run), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", int'({row_sel,pix_rst,amp_rst,cmp_az,tx,sh,ramp_run,ramp_up,cnt_en,inv,done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle outputs", int'({row_sel,pix_rst,amp_rst,cmp_az,tx,sh,ramp_run,ramp_up,cnt_en,inv,done}), 0);
    for (int i = 0; i < 6; i++) run_row(VEC[i], 1'b0);
    // R11: start and config changes mid-row leave the row untouched
    run_row(VEC[1], 1'b1);
    run_row(VEC[0], 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule